// File: doc/BRIEF.md
# HDLC Frame Transmitter with Automatic Underrun Abort

This block turns bytes that a host places in a small on-chip queue into a serial HDLC bit stream. Each queue entry carries a data byte and a flag that marks it as the final byte of its message. When the queue holds data and the line reaches a byte boundary, the block sends an opening flag. It then sends the message bytes least significant bit first, with zero-bit insertion, followed by the inverted CRC-16 and a closing flag. Between frames the line carries back-to-back flag octets.

The line advances one bit on each cycle in which the bit strobe is high. If the queue is empty when the next message byte is due, and the final byte has not yet been sent, the frame cannot be finished. The block then sends an abort pattern by itself, returns to flag fill, and latches an underrun event. The host clears that event by pulsing the event-read strobe. Full and empty indications follow the queue occupancy on every cycle.

Top module: `hdlc_tx_top`

## Requirements
- R1: When no frame is pending, the line carries continuous flag octets 0x7E, sent least significant bit first as 0,1,1,1,1,1,1,0.
- R2: A frame starts only while the queue holds at least one byte. The flag in progress serves as the opening flag, and the queued bytes follow in write order, each sent least significant bit first.
- R3: Inside the data and CRC fields, a 0 bit is inserted after every run of five consecutive 1 bits. Flags and the abort pattern are never stuffed.
- R4: After the byte whose end mark (`wr_last`=1) is set, the block sends the ones' complement of the CRC-16, low byte first, then one 0x7E flag. The CRC uses the reflected polynomial 0x8408 and a preset of 0xFFFF, and covers the message bytes only. For the ASCII string "123456789" the two bytes sent are 0x6E then 0x90.
- R5: If the queue is empty when the next message byte is needed, and the final byte has not been sent, the block sends 0xFF (exactly eight 1 bits after data ending in 0) instead of more data. Flag fill follows.
- R6: `underrun_evt` goes high on the cycle after an abort is started. It stays high until `ev_rd` is pulsed, and a new underrun in the same cycle as `ev_rd` keeps it set.
- R7: `fifo_full` is high exactly when DEPTH entries are stored. `fifo_empty` is high exactly when none are stored. Both update on every write and pop.
- R8: A write while `fifo_full` is high is ignored, and the stored entries are sent unchanged.
- R9: In reset, `fifo_empty`=1, `fifo_full`=0, `underrun_evt`=0 and `tx_bit`=1.
- R10: When `bit_en` is low, `tx_bit` holds its value and the frame state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit strobe: one serial bit is produced per high cycle |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | Marks the written byte as the final byte of its message |
| ev_rd | input | 1 | Event read strobe, clears the latched underrun event |
| tx_bit | output | 1 | Serial HDLC line output |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_empty | output | 1 | Queue holds no entries |
| underrun_evt | output | 1 | Latched underrun event |

## Verification
The bench targets the following corner cases, each chosen because a specific defect would show up in it:
- **Stuffing at a field boundary.** Bytes full of ones, and a data byte equal to the flag value, force a stuff bit at the edge of a field. A design that counted ones across a flag, or that lost the pending zero at a byte boundary, would show a run of six ones inside a frame.
- **CRC value and byte order.** The known check string tests the CRC arithmetic. A design with the wrong preset, the wrong bit order or the wrong byte order would not match the literal bytes 0x6E and 0x90.
- **Underrun.** Starving the queue in mid-message must produce exactly eight 1 bits, then flags, and a sticky event that clears only on the read strobe. A design that stuffed the abort, or that kept waiting for data, would fail here.
- **Queue limits.** The queue is filled to capacity with the line stopped, and one extra write is then attempted. A design that accepted that write, or that mis-timed the full flag by one entry, would send a different frame or report the wrong flag value.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int unsigned OCTET = 8;

  localparam logic [OCTET-1:0] FLAG_OCTET  = 8'h7E;
  localparam logic [OCTET-1:0] ABORT_OCTET = 8'hFF;

  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_DATA,
    FR_CRCL,
    FR_CRCH,
    FR_CLOSE
  } fr_state_t;

  // One byte through the reflected CRC-16, least significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                             input logic [OCTET-1:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < OCTET; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
  logic [AW:0]   cnt;
  logic          push, pop;

  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;
  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign rd_data = mem[rptr];

  generate
    if (POW2) begin : g_wrap_p2
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wptr_nx = (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wptr_nx;
      if (pop)  rptr <= rptr_nx;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: the two occupancy flags are never high together
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R8: a write into a full queue with no pop leaves it full
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> full);

  // R7: a write into an empty queue makes it non-empty
  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && wr_en) |=> !empty);

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [OCTET-1:0] head_data,
  input  logic             head_last,
  input  logic             q_empty,
  output logic [OCTET-1:0] nxt_byte,
  output logic             nxt_stuff,
  output logic             pop,
  output logic             urun_pulse
);

  fr_state_t   st;
  logic [15:0] crc;
  logic [15:0] fcs;

  assign fcs = ~crc;

  always_comb begin
    nxt_byte  = FLAG_OCTET;
    nxt_stuff = 1'b0;
    case (st)
      FR_DATA: begin
        if (!q_empty) begin
          nxt_byte  = head_data;
          nxt_stuff = 1'b1;
        end else begin
          nxt_byte  = ABORT_OCTET;
          nxt_stuff = 1'b0;
        end
      end
      FR_CRCL: begin
        nxt_byte  = fcs[7:0];
        nxt_stuff = 1'b1;
      end
      FR_CRCH: begin
        nxt_byte  = fcs[15:8];
        nxt_stuff = 1'b1;
      end
      default: begin
        nxt_byte  = FLAG_OCTET;
        nxt_stuff = 1'b0;
      end
    endcase
  end

  assign pop        = take && (st == FR_DATA) && !q_empty;
  assign urun_pulse = take && (st == FR_DATA) &&  q_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= FR_IDLE;
      crc <= CRC_PRESET;
    end else if (take) begin
      case (st)
        FR_IDLE: begin
          crc <= CRC_PRESET;
          if (!q_empty) st <= FR_DATA;
        end
        FR_DATA: begin
          if (!q_empty) begin
            crc <= crc16_step(crc, head_data);
            if (head_last) st <= FR_CRCL;
          end else begin
            st <= FR_IDLE;
          end
        end
        FR_CRCL:  st <= FR_CRCH;
        FR_CRCH:  st <= FR_CLOSE;
        default:  st <= FR_IDLE;
      endcase
    end
  end

  // R2: no frame starts from an empty queue
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_IDLE && take && q_empty) |=> (st == FR_IDLE));

  // R4: the low CRC byte is always followed by the high one
  p_crc_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_CRCL && take) |=> (st == FR_CRCH));

  // R10: without a byte request the state holds
  p_state_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(st));

endmodule

// File: rtl/hdlc_tx_bitser.sv
module hdlc_tx_bitser
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned RUN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [OCTET-1:0] nxt_byte,
  input  logic             nxt_stuff,
  output logic             take,
  output logic             tx_bit
);

  localparam int unsigned CW = $clog2(OCTET);
  localparam int unsigned OW = $clog2(RUN + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(OCTET - 1);
  localparam logic [OW-1:0] RUN_MAX  = OW'(RUN);

  logic [OCTET-2:0] sh;
  logic [CW-1:0]    left;
  logic [OW-1:0]    ones;
  logic             cur_stuff;
  logic             stuff_now;
  logic             load;
  logic             b_out;
  logic             b_stuffable;

  assign stuff_now   = (ones == RUN_MAX);
  assign load        = (left == '0);
  assign take        = bit_en && !stuff_now && load;
  assign b_out       = load ? nxt_byte[0] : sh[0];
  assign b_stuffable = load ? nxt_stuff   : cur_stuff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      left      <= '0;
      ones      <= '0;
      cur_stuff <= 1'b0;
      tx_bit    <= 1'b1;
    end else if (bit_en) begin
      if (stuff_now) begin
        tx_bit <= 1'b0;
        ones   <= '0;
      end else begin
        tx_bit <= b_out;
        ones   <= (b_stuffable && b_out) ? ones + 1'b1 : '0;
        if (load) begin
          sh        <= nxt_byte[OCTET-1:1];
          left      <= LAST_IDX;
          cur_stuff <= nxt_stuff;
        end else begin
          sh   <= sh >> 1;
          left <= left - 1'b1;
        end
      end
    end
  end

  // R3: a full run of stuffable ones is followed on the line by a zero
  p_stuff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ones == RUN_MAX) |=> (tx_bit == 1'b0));

  // R10: the line output holds while the strobe is low
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

endmodule

// File: rtl/hdlc_tx_top.sv
module hdlc_tx_top
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned RUN   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             wr_en,
  input  logic [OCTET-1:0] wr_data,
  input  logic             wr_last,
  input  logic             ev_rd,
  output logic             tx_bit,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             underrun_evt
);

  localparam int unsigned EW = OCTET + 1;

  logic [EW-1:0]    head;
  logic             fifo_pop;
  logic             byte_take;
  logic             urun_pulse;
  logic [OCTET-1:0] nxt_byte;
  logic             nxt_stuff;

  hdlc_tx_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data ({wr_last, wr_data}),
    .rd_en   (fifo_pop),
    .rd_data (head),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  hdlc_tx_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (byte_take),
    .head_data  (head[OCTET-1:0]),
    .head_last  (head[OCTET]),
    .q_empty    (fifo_empty),
    .nxt_byte   (nxt_byte),
    .nxt_stuff  (nxt_stuff),
    .pop        (fifo_pop),
    .urun_pulse (urun_pulse)
  );

  hdlc_tx_bitser #(.RUN(RUN)) u_bitser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .nxt_byte  (nxt_byte),
    .nxt_stuff (nxt_stuff),
    .take      (byte_take),
    .tx_bit    (tx_bit)
  );

  // Sticky event: a new underrun takes priority over the read clear.
  always_ff @(posedge clk) begin
    if (!rst_n)          underrun_evt <= 1'b0;
    else if (urun_pulse) underrun_evt <= 1'b1;
    else if (ev_rd)      underrun_evt <= 1'b0;
  end

  // R5: an abort is started only when the queue is dry
  p_urun_dry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    urun_pulse |-> fifo_empty);

  // R6: an underrun is seen on the event output next cycle
  p_evt_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    urun_pulse |=> underrun_evt);

  // R6: a read with no fresh underrun clears the event
  p_evt_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd && !urun_pulse) |=> !underrun_evt);

  // R6: the event does not drop by itself
  p_evt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_evt && !ev_rd) |=> underrun_evt);

endmodule

// File: tb/tb_hdlc_tx_top.sv
module tb_hdlc_tx_top;

  localparam int DEPTH = 16;
  localparam int NV    = 5;
  localparam int TMO   = 150000;

  // Stimulus table: length, bytes (byte k at bits 8k+7:8k), literal FCS (0 = compute), strobe gap
  localparam int          VLEN [NV] = '{1, 3, 9, 4, 16};
  localparam logic [127:0] VDAT [NV] = '{
    128'h7E,
    128'hFFFFFF,
    128'h393837363534333231,
    128'h0,
    128'hF0E1D2C3B4A5968778695A4B3C2D1E0F
  };
  localparam logic [15:0] VFCS [NV] = '{16'h0, 16'h0, 16'h906E, 16'h0, 16'h0};
  localparam bit          VGAP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_last = 1'b0;
  logic       ev_rd = 1'b0;
  logic       tx_bit, fifo_full, fifo_empty, underrun_evt;

  int  n_chk = 0;
  int  n_bad = 0;
  int  line_mode = 0;   // 0 = every cycle, 1 = every other cycle, 2 = stopped
  bit  rec_on = 1'b0;
  bit  rec [$];
  bit  expq [$];

  always #2 clk = ~clk;

  hdlc_tx_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en),
    .wr_data(wr_data), .wr_last(wr_last), .ev_rd(ev_rd),
    .tx_bit(tx_bit), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .underrun_evt(underrun_evt)
  );

  // Record the line for every strobe of the previous edge, then set the next strobe.
  always @(negedge clk) begin
    if (rec_on && bit_en) rec.push_back(tx_bit);
    case (line_mode)
      0:       bit_en = 1'b1;
      1:       bit_en = ~bit_en;
      default: bit_en = 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bit-serial reflected CRC written as a shift with feedback taps.
  function automatic logic [15:0] crc_bit(input logic [15:0] c, input bit b);
    logic fb;
    logic [15:0] n;
    fb = c[0] ^ b;
    n = {fb, c[15:1]};
    n[10] = c[11] ^ fb;
    n[3]  = c[4] ^ fb;
    return n;
  endfunction

  task automatic push_stuffed(input logic [7:0] v, inout int ones);
    for (int i = 0; i < 8; i++) begin
      expq.push_back(v[i]);
      if (v[i]) ones++; else ones = 0;
      if (ones == 5) begin
        expq.push_back(1'b0);
        ones = 0;
      end
    end
  endtask

  // Expected frame body after the opening flag: stuffed data and FCS, then the closing flag.
  task automatic build_exp(input int len, input logic [127:0] d, input logic [15:0] lit);
    logic [15:0] c;
    logic [15:0] fcs;
    int ones;
    expq.delete();
    c = 16'hFFFF;
    ones = 0;
    for (int k = 0; k < len; k++) begin
      for (int i = 0; i < 8; i++) c = crc_bit(c, d[8*k+i]);
      push_stuffed(d[8*k +: 8], ones);
    end
    fcs = (lit != 16'h0) ? lit : ~c;
    push_stuffed(fcs[7:0], ones);
    push_stuffed(fcs[15:8], ones);
    for (int i = 0; i < 8; i++) expq.push_back(8'h7E >> i);
  endtask

  function automatic bit flag_at(input int p);
    for (int i = 0; i < 8; i++) if (rec[p+i] != ((8'h7E >> i) & 1)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit frame_found();
    int m;
    m = expq.size();
    for (int p = 8; p + m <= rec.size(); p++) begin
      if (flag_at(p-8)) begin
        bit ok;
        ok = 1'b1;
        for (int j = 0; j < m; j++) if (rec[p+j] != expq[j]) begin ok = 1'b0; break; end
        if (ok) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  function automatic int longest_ones();
    int run, best;
    run = 0; best = 0;
    foreach (rec[i]) begin
      if (rec[i]) run++; else run = 0;
      if (run > best) best = run;
    end
    return best;
  endfunction

  task automatic write_frame(input int len, input logic [127:0] d, input bit last);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d[8*k +: 8];
      wr_last = last && (k == len - 1);
    end
    @(negedge clk);
    wr_en = 1'b0;
    wr_last = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * TMO);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    // R9: reset values
    repeat (4) @(negedge clk);
    check(fifo_empty == 1'b1, "R9 empty", fifo_empty, 1);
    check(fifo_full == 1'b0, "R9 full", fifo_full, 0);
    check(underrun_evt == 1'b0, "R9 event", underrun_evt, 0);
    check(tx_bit == 1'b1, "R9 line", tx_bit, 1);
    rst_n = 1'b1;
    rec.delete();
    rec_on = 1'b1;
    repeat (40) @(negedge clk);
    // R1: three back-to-back flags at some alignment
    begin
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 8; k++)
        if (flag_at(k) && flag_at(k+8) && flag_at(k+16)) seen = 1'b1;
      check(seen, "R1 idle flags", seen, 1);
    end

    // Table walk: R2, R3, R4, R10 (gapped strobe), R7 after draining
    for (int v = 0; v < NV; v++) begin
      line_mode = VGAP[v] ? 1 : 0;
      rec.delete();
      build_exp(VLEN[v], VDAT[v], VFCS[v]);
      write_frame(VLEN[v], VDAT[v], 1'b1);
      repeat (700) @(negedge clk);
      check(frame_found(), $sformatf("R2 R3 R4 R10 frame v%0d", v), 0, 1);
      check(fifo_empty == 1'b1, $sformatf("R7 drained v%0d", v), fifo_empty, 1);
    end
    line_mode = 0;

    // Underrun: R5 and R6
    repeat (20) @(negedge clk);
    rec.delete();
    write_frame(2, 128'h0, 1'b0);
    repeat (200) @(negedge clk);
    check(longest_ones() == 8, "R5 abort run", longest_ones(), 8);
    check(underrun_evt == 1'b1, "R6 event set", underrun_evt, 1);
    repeat (50) @(negedge clk);
    check(underrun_evt == 1'b1, "R6 event held", underrun_evt, 1);
    begin
      int tail;
      bit flags_back;
      tail = rec.size();
      flags_back = 1'b0;
      for (int k = tail - 24; k < tail - 8; k++) if (flag_at(k)) flags_back = 1'b1;
      check(flags_back, "R5 flags after abort", flags_back, 1);
    end
    ev_rd = 1'b1;
    @(negedge clk);
    ev_rd = 1'b0;
    check(underrun_evt == 1'b0, "R6 event cleared", underrun_evt, 0);
    check(fifo_empty == 1'b1, "R7 empty after abort", fifo_empty, 1);

    // Full queue with the line stopped: R7, R8
    line_mode = 2;
    repeat (4) @(negedge clk);
    write_frame(DEPTH - 1, VDAT[4], 1'b0);
    check(fifo_full == 1'b0, "R7 not full at DEPTH-1", fifo_full, 0);
    check(fifo_empty == 1'b0, "R7 not empty", fifo_empty, 0);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = VDAT[4][8*(DEPTH-1) +: 8];
    wr_last = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wr_last = 1'b0;
    check(fifo_full == 1'b1, "R7 full at DEPTH", fifo_full, 1);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'hAA;
    wr_last = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wr_last = 1'b0;
    check(fifo_full == 1'b1, "R8 still full", fifo_full, 1);
    rec.delete();
    build_exp(DEPTH, VDAT[4], 16'h0);
    line_mode = 0;
    repeat (700) @(negedge clk);
    check(frame_found(), "R8 stored frame intact", 0, 1);
    check(fifo_empty == 1'b1, "R8 extra byte dropped", fifo_empty, 1);
    check(underrun_evt == 1'b0, "R6 no spurious event", underrun_evt, 0);

    finish_run();
  end

endmodule